// File: doc/BRIEF.md
# Bytewise CRC-32 Engine (Polynomial 0x20044009, MSB-First)

This block keeps a running 32-bit CRC over a byte stream that protects command blocks. Its generator is the uncommon polynomial x^32 + x^29 + x^18 + x^14 + x^3 + 1, written 0x20044009 with the x^32 term left implicit. Bits are consumed most significant first. There is no input or output reflection, and the result is never complemented.

A caller starts a message by pulsing `init_i` with a seed on `seed_i`, which is normally 0xFFFFFFFF. After that, it presents one byte per cycle on `byte_i` with `byte_valid_i`. A byte is taken in every cycle where `byte_valid_i` and `byte_ready_o` are both high. The register value shows on `crc_o` at all times. A pulse on `init_i` may coincide with the first byte, and in that case the byte is folded straight into the seed. The folding network is combinational. A parameter picks one of two forms: a 256-entry lookup indexed by the top CRC byte XOR the data byte, or eight unrolled shift-and-XOR steps.

Top module: `crc32b_engine`

## Requirements
- R1: While `rst` is high at a rising edge, the register becomes 0xFFFFFFFF on that edge, and bytes offered during reset are not taken.
- R2: `byte_ready_o` is low while `rst` is high and high whenever `rst` is low.
- R3: If `init_i` is high and no byte is taken, `crc_o` equals the `seed_i` value of that cycle after the next edge.
- R4: A byte taken without `init_i` updates `crc_o` on the next edge to the MSB-first fold of that byte into the previous value. Byte bit 7 is processed first. Each step shifts left and XORs 0x20044009 when the bit leaving position 31, XORed with the data bit, is 1.
- R5: If `init_i` is high and a byte is taken in the same cycle, the result after the next edge is the fold of that byte into `seed_i`.
- R6: In a cycle with neither `init_i` nor a taken byte, `crc_o` does not change.
- R7: With seed 0xFFFFFFFF, the bytes 0x01, 0x02, 0x03, 0x04 give 0xF33CB7D3.
- R8: No final XOR and no bit reversal are applied. Seed 0x00000000 with byte 0x00 gives 0x00000000, and seed 0x00000000 with byte 0x01 gives 0x20044009.
- R9: A stream of bytes taken in back-to-back cycles updates `crc_o` once per byte, one byte per cycle, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| init_i | input | 1 | Load `seed_i` into the CRC register |
| seed_i | input | 32 | Starting value for a new message |
| byte_valid_i | input | 1 | `byte_i` holds a byte to fold |
| byte_i | input | 8 | Data byte |
| byte_ready_o | output | 1 | The block accepts a byte this cycle |
| crc_o | output | 32 | Running CRC register |

## Verification
The only internal state is the CRC register. A wrong fold, table entry or select shows on `crc_o` one edge after the byte that caused it. Because the CRC has no final masking, a single wrong bit then spreads through every later byte and cannot cancel out. The sweep therefore folds all 256 byte values into two different seeds, so that every table index and every feedback pattern is compared on the cycle it is used. Long chained streams catch errors in how consecutive bytes are linked.

// File: rtl/crc32b_pkg.sv
package crc32b_pkg;

    localparam int CRC_W  = 32;
    localparam int BYTE_W = 8;
    localparam int TBL_N  = 1 << BYTE_W;

    localparam logic [CRC_W-1:0] DEF_POLY  = 32'h2004_4009;
    localparam logic [CRC_W-1:0] DEF_RESET = 32'hFFFF_FFFF;

    typedef enum logic [0:0] {
        FOLD_TABLE = 1'b0,
        FOLD_XOR   = 1'b1
    } fold_impl_e;

    typedef struct packed {
        logic              load;
        logic [CRC_W-1:0]  seed;
        logic              take;
        logic [BYTE_W-1:0] data;
    } crc_cmd_t;

    // Table entry: index placed in the top byte, then eight plain shifts.
    function automatic logic [CRC_W-1:0] table_entry(
        input logic [BYTE_W-1:0] idx,
        input logic [CRC_W-1:0]  poly
    );
        logic [CRC_W-1:0] r;
        r = {idx, {(CRC_W-BYTE_W){1'b0}}};
        for (int k = 0; k < BYTE_W; k++) begin
            if (r[CRC_W-1]) r = {r[CRC_W-2:0], 1'b0} ^ poly;
            else            r = {r[CRC_W-2:0], 1'b0};
        end
        return r;
    endfunction

    // One feedback step with the data bit injected at the top.
    function automatic logic [CRC_W-1:0] bit_step(
        input logic [CRC_W-1:0] r,
        input logic             din,
        input logic [CRC_W-1:0] poly
    );
        logic fb;
        fb = r[CRC_W-1] ^ din;
        return {r[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    endfunction

endpackage

// File: rtl/crc32b_fold_table.sv
module crc32b_fold_table
    import crc32b_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = DEF_POLY
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [BYTE_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);
    localparam int SHIFT_W = CRC_W - BYTE_W;

    logic [CRC_W-1:0]  lut [TBL_N];
    logic [BYTE_W-1:0] idx;

    for (genvar g = 0; g < TBL_N; g++) begin : g_lut
        assign lut[g] = table_entry(BYTE_W'(g), POLY);
    end

    assign idx     = crc_in[CRC_W-1 -: BYTE_W] ^ data_in;
    assign crc_out = {crc_in[SHIFT_W-1:0], {BYTE_W{1'b0}}} ^ lut[idx];
endmodule

// File: rtl/crc32b_fold_xor.sv
module crc32b_fold_xor
    import crc32b_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = DEF_POLY
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [BYTE_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);
    logic [CRC_W-1:0] stage [BYTE_W+1];

    assign stage[0] = crc_in;
    for (genvar s = 0; s < BYTE_W; s++) begin : g_step
        assign stage[s+1] = bit_step(stage[s], data_in[BYTE_W-1-s], POLY);
    end
    assign crc_out = stage[BYTE_W];
endmodule

// File: rtl/crc32b_fold.sv
module crc32b_fold
    import crc32b_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = DEF_POLY,
    parameter fold_impl_e       IMPL = FOLD_TABLE
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [BYTE_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);
    if (IMPL == FOLD_TABLE) begin : g_table
        crc32b_fold_table #(.POLY(POLY)) u_fold (
            .crc_in (crc_in),
            .data_in(data_in),
            .crc_out(crc_out)
        );
    end else begin : g_xor
        crc32b_fold_xor #(.POLY(POLY)) u_fold (
            .crc_in (crc_in),
            .data_in(data_in),
            .crc_out(crc_out)
        );
    end
endmodule

// File: rtl/crc32b_state.sv
module crc32b_state
    import crc32b_pkg::*;
#(
    parameter logic [CRC_W-1:0] RESET_VAL = DEF_RESET
) (
    input  logic             clk,
    input  logic             rst,
    input  crc_cmd_t         cmd,
    input  logic [CRC_W-1:0] folded,
    output logic [CRC_W-1:0] base,
    output logic [CRC_W-1:0] crc_q
);
    logic [CRC_W-1:0] crc_d;

    assign base = cmd.load ? cmd.seed : crc_q;

    always_comb begin
        crc_d = crc_q;
        if (cmd.take)      crc_d = folded;
        else if (cmd.load) crc_d = cmd.seed;
    end

    always_ff @(posedge clk) begin
        if (rst) crc_q <= RESET_VAL;
        else     crc_q <= crc_d;
    end
endmodule

// File: rtl/crc32b_engine.sv
module crc32b_engine
    import crc32b_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY      = DEF_POLY,
    parameter logic [CRC_W-1:0] RESET_VAL = DEF_RESET,
    parameter fold_impl_e       IMPL      = FOLD_TABLE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init_i,
    input  logic [CRC_W-1:0]  seed_i,
    input  logic              byte_valid_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              byte_ready_o,
    output logic [CRC_W-1:0]  crc_o
);
    crc_cmd_t         cmd;
    logic [CRC_W-1:0] base;
    logic [CRC_W-1:0] folded;

    assign byte_ready_o = ~rst;

    assign cmd.load = init_i;
    assign cmd.seed = seed_i;
    assign cmd.take = byte_valid_i & byte_ready_o;
    assign cmd.data = byte_i;

    crc32b_fold #(.POLY(POLY), .IMPL(IMPL)) u_fold (
        .crc_in (base),
        .data_in(cmd.data),
        .crc_out(folded)
    );

    crc32b_state #(.RESET_VAL(RESET_VAL)) u_state (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .folded(folded),
        .base  (base),
        .crc_q (crc_o)
    );
endmodule

// File: rtl/crc32b_engine_chk.sv
module crc32b_engine_chk
    import crc32b_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY      = DEF_POLY,
    parameter logic [CRC_W-1:0] RESET_VAL = DEF_RESET
) (
    input logic              clk,
    input logic              rst,
    input logic              init_i,
    input logic [CRC_W-1:0]  seed_i,
    input logic              byte_valid_i,
    input logic [BYTE_W-1:0] byte_i,
    input logic              byte_ready_o,
    input logic [CRC_W-1:0]  crc_o
);
    // Serial reference: long division of the byte into the register.
    function automatic logic [CRC_W-1:0] ser_fold(
        input logic [CRC_W-1:0]  c,
        input logic [BYTE_W-1:0] d
    );
        logic [CRC_W-1:0] r;
        r = c ^ {d, {(CRC_W-BYTE_W){1'b0}}};
        for (int k = 0; k < BYTE_W; k++)
            r = r[CRC_W-1] ? ((r << 1) ^ POLY) : (r << 1);
        return r;
    endfunction

    logic taken;
    assign taken = byte_valid_i && byte_ready_o;

    AST_RESET_VALUE: assert property (@(posedge clk)
        rst |=> crc_o == RESET_VAL); // R1

    AST_READY_OUT_OF_RESET: assert property (@(posedge clk) disable iff (rst)
        byte_ready_o); // R2

    AST_SEED_LOAD: assert property (@(posedge clk) disable iff (rst)
        (init_i && !taken) |=> crc_o == $past(seed_i)); // R3

    AST_BYTE_FOLD: assert property (@(posedge clk) disable iff (rst)
        (taken && !init_i) |=> crc_o == ser_fold($past(crc_o), $past(byte_i))); // R4

    AST_SEED_FOLD: assert property (@(posedge clk) disable iff (rst)
        (taken && init_i) |=> crc_o == ser_fold($past(seed_i), $past(byte_i))); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!init_i && !taken) |=> $stable(crc_o)); // R6
endmodule

bind crc32b_engine crc32b_engine_chk #(.POLY(POLY), .RESET_VAL(RESET_VAL)) u_chk (.*);

// File: tb/crc32b_engine_test.sv
module crc32b_engine_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        init_i;
    logic [31:0] seed_i;
    logic        byte_valid_i;
    logic [7:0]  byte_i;
    logic        byte_ready_o;
    logic [31:0] crc_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    crc32b_engine uut (
        .clk         (clk),
        .rst         (rst),
        .init_i      (init_i),
        .seed_i      (seed_i),
        .byte_valid_i(byte_valid_i),
        .byte_i      (byte_i),
        .byte_ready_o(byte_ready_o),
        .crc_o       (crc_o)
    );

    // Arithmetic model: XOR the byte into the top, divide bit by bit.
    function automatic logic [31:0] model(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ (32'(d) << 24);
        for (int k = 0; k < 8; k++)
            r = r[31] ? ((r << 1) ^ 32'h2004_4009) : (r << 1);
        return r;
    endfunction

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Drive on the falling edge, sample just after the next rising edge.
    task automatic cyc(input logic ini, input logic [31:0] sd, input logic v, input logic [7:0] b);
        @(negedge clk);
        init_i = ini; seed_i = sd; byte_valid_i = v; byte_i = b;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp;
        logic [7:0]  lfsr;
        rst = 1'b1; init_i = 1'b0; seed_i = '0; byte_valid_i = 1'b0; byte_i = '0;

        // R1/R2: reset state, bytes offered during reset are not taken
        cyc(1'b0, 32'h0, 1'b1, 8'h5A);
        cyc(1'b0, 32'h0, 1'b1, 8'hC3);
        check32("R1 reset value", crc_o, 32'hFFFF_FFFF);
        check32("R2 ready low in reset", 32'(byte_ready_o), 32'd0);
        @(negedge clk); rst = 1'b0; byte_valid_i = 1'b0;
        #1;
        check32("R2 ready high after reset", 32'(byte_ready_o), 32'd1);

        // R7: published vector
        cyc(1'b1, 32'hFFFF_FFFF, 1'b1, 8'h01);
        cyc(1'b0, 32'h0, 1'b1, 8'h02);
        cyc(1'b0, 32'h0, 1'b1, 8'h03);
        cyc(1'b0, 32'h0, 1'b1, 8'h04);
        check32("R7 vector 01020304", crc_o, 32'hF33C_B7D3);

        // R6: idle cycles hold the value
        cyc(1'b0, 32'h1234_5678, 1'b0, 8'hAA);
        cyc(1'b0, 32'h1234_5678, 1'b0, 8'h55);
        check32("R6 hold", crc_o, 32'hF33C_B7D3);

        // R3: seed load without a byte
        cyc(1'b1, 32'hDEAD_BEEF, 1'b0, 8'h77);
        check32("R3 seed load", crc_o, 32'hDEAD_BEEF);

        // R8: no final XOR, no reflection
        cyc(1'b1, 32'h0, 1'b1, 8'h00);
        check32("R8 zero in zero out", crc_o, 32'h0);
        cyc(1'b1, 32'h0, 1'b1, 8'h01);
        check32("R8 single bit gives poly", crc_o, 32'h2004_4009);

        // R5: every byte folded into two seeds in the init cycle
        for (int b = 0; b < 256; b++) begin
            cyc(1'b1, 32'hFFFF_FFFF, 1'b1, 8'(b));
            check32("R5 init+byte seed ones", crc_o, model(32'hFFFF_FFFF, 8'(b)));
            cyc(1'b1, 32'h0F1E_2D3C, 1'b1, 8'(b));
            check32("R5 init+byte seed mix", crc_o, model(32'h0F1E_2D3C, 8'(b)));
        end

        // R4: every byte folded into a running value
        cyc(1'b1, 32'h8000_0001, 1'b0, 8'h00);
        exp = 32'h8000_0001;
        for (int b = 0; b < 256; b++) begin
            cyc(1'b0, 32'h0, 1'b1, 8'(255 - b));
            exp = model(exp, 8'(255 - b));
            check32("R4 byte fold", crc_o, exp);
        end

        // R9: back-to-back stream with gaps mixed in
        cyc(1'b1, 32'hFFFF_FFFF, 1'b0, 8'h00);
        exp  = 32'hFFFF_FFFF;
        lfsr = 8'hB5;
        for (int n = 0; n < 600; n++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (n % 37 == 36) begin
                cyc(1'b0, 32'h0, 1'b0, lfsr);
                check32("R6 gap in stream", crc_o, exp);
            end else begin
                cyc(1'b0, 32'h0, 1'b1, lfsr);
                exp = model(exp, lfsr);
                check32("R9 streamed byte", crc_o, exp);
            end
        end

        // R1 again: reset mid-message returns to the reset value
        @(negedge clk); rst = 1'b1; byte_valid_i = 1'b1; byte_i = 8'h99;
        @(posedge clk); #1;
        check32("R1 reset mid-stream", crc_o, 32'hFFFF_FFFF);
        check32("R2 ready low in reset", 32'(byte_ready_o), 32'd0);
        @(negedge clk); rst = 1'b0; byte_valid_i = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule